// File: doc/BRIEF.md
# Sign-Magnitude PCM Compander with Linear and Segmented Modes

This block turns a sign-magnitude audio sample into one byte for a fixed 8-bit channel and rebuilds a magnitude from that byte again. The sample has a sign flag and a 12-bit magnitude. A mode input picks one of two ways of fitting the magnitude into the 7 magnitude bits of the byte. The linear way keeps only the top bits. The segmented way uses a logarithmic code made of a segment number and a mantissa. Small magnitudes keep their fine detail, so the relative error at low levels is far lower than with truncation.

The compressor takes one sample each cycle when the sample is qualified as valid. It registers the byte, together with the mode that produced it, one cycle later. A combinational expander reads that registered byte and drives a 12-bit magnitude and a sign onto the output. A system can therefore watch both the channel byte and the reconstructed sample from the same port set. Both paths share one channel byte layout, and the mode can change from one sample to the next.

Top module: `pcm_compander_top`

## Requirements
- R1: After reset, out_valid is 0 and out_byte is 0x00. With the reset mode being linear, out_mag is 0 and out_sign is 0.
- R2: Byte layout: bit 7 holds the sign (1 = negative) and bits 6:0 hold the magnitude code. The sign reaches out_byte[7] and out_sign unchanged in both modes.
- R3: out_valid is in_valid delayed by exactly one clock. A sample offered with in_valid high appears on out_byte on the following cycle.
- R4: While in_valid is low, out_byte, out_sign and out_mag hold their previous values, whatever the other inputs do.
- R5: Linear mode (mode_alaw = 0): the code is magnitude bits 11:5. The expander returns the code shifted left by 5, so its low 5 bits are zero.
- R6: Segmented mode (mode_alaw = 1): code bits 6:4 are the segment. The segment is 0 for magnitudes below 32. Otherwise it is s, where bit s+4 is the highest set bit of the magnitude.
- R7: Segmented mantissa (code bits 3:0): in segments 0 and 1 it is magnitude bits 4:1. In segment s of 2 or more it is magnitude bits s+3:s.
- R8: In segmented mode these magnitudes give these codes: 0x02E→0x17, 0x03E→0x1F, 0x060→0x28, 0x07C→0x2F, 0x7C0→0x6F, 0x800→0x70, 0xC00→0x78, 0xF80→0x7F.
- R9: Segmented expansion works from the segment base and a step size. The base is 0 for segment 0 and 2^(s+4) otherwise. The step is 2 for segments 0 and 1 and 2^s otherwise. The output is base + mantissa·step + step/2.
- R10: The mode is captured with each valid sample. The expander uses the mode of the byte it holds, so changing the mode between back-to-back samples affects only the later sample.
- R11: In segmented mode the expanded magnitude always lies inside the interval its code stands for. Compressing it again gives the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_sign | input | 1 | Sample sign, 1 = negative |
| in_mag | input | 12 | Sample magnitude |
| mode_alaw | input | 1 | 0 = linear truncation, 1 = segmented compression |
| out_valid | output | 1 | Byte produced this cycle |
| out_byte | output | 8 | Channel byte: sign and 7-bit code |
| out_sign | output | 1 | Expanded sign |
| out_mag | output | 12 | Expanded 12-bit magnitude |

## Verification
The bench builds the block with its default widths: a 12-bit magnitude, 3 segment bits and 4 mantissa bits. At this size the input space holds only 4096 magnitudes per mode. The bench therefore sweeps every magnitude in both modes, compares each byte and each expanded value with a threshold-search model, and checks the round trip. Directed scenarios add the listed code points, the sign, the holding behaviour when the sample is idle, the one-cycle latency, and a mode flip between back-to-back samples.

// File: rtl/pcm_cmp_pkg.sv
package pcm_cmp_pkg;
  typedef enum logic {
    MODE_LINEAR = 1'b0,
    MODE_SEGMENT = 1'b1
  } pcm_mode_e;
endpackage

// File: rtl/pcm_seg_encoder.sv
module pcm_seg_encoder
  import pcm_cmp_pkg::*;
#(
  parameter int MAG_W  = 12,
  parameter int SEG_W  = 3,
  parameter int MANT_W = 4
) (
  input  logic [MAG_W-1:0]          mag,
  input  pcm_mode_e                 mode,
  output logic [SEG_W+MANT_W-1:0]   code
);
  localparam int CODE_W = SEG_W + MANT_W;
  localparam int NSEG   = 1 << SEG_W;

  // segment = position of the leading one above the two lowest segments
  function automatic logic [CODE_W-1:0] seg_code(input logic [MAG_W-1:0] m);
    logic [SEG_W-1:0] seg;
    logic [MAG_W-1:0] shifted;
    int               shamt;
    seg = '0;
    for (int s = 1; s < NSEG; s++) begin
      if ((m >> (MANT_W + s)) != '0) seg = SEG_W'(s);
    end
    shamt   = (seg == '0) ? 1 : int'(seg);
    shifted = m >> shamt;
    return {seg, shifted[MANT_W-1:0]};
  endfunction

  function automatic logic [CODE_W-1:0] lin_code(input logic [MAG_W-1:0] m);
    return m[MAG_W-1 -: CODE_W];
  endfunction

  logic [CODE_W-1:0] code_lin;
  logic [CODE_W-1:0] code_seg;

  assign code_lin = lin_code(mag);
  assign code_seg = seg_code(mag);
  assign code     = (mode == MODE_SEGMENT) ? code_seg : code_lin;
endmodule

// File: rtl/pcm_seg_decoder.sv
module pcm_seg_decoder
  import pcm_cmp_pkg::*;
#(
  parameter int MAG_W  = 12,
  parameter int SEG_W  = 3,
  parameter int MANT_W = 4
) (
  input  logic [SEG_W+MANT_W-1:0] code,
  input  pcm_mode_e               mode,
  output logic [MAG_W-1:0]        mag
);
  localparam int CODE_W = SEG_W + MANT_W;
  localparam int PAD_W  = MAG_W - CODE_W;

  // base of the segment plus mantissa steps plus half a step
  function automatic logic [MAG_W-1:0] seg_mag(input logic [CODE_W-1:0] c);
    logic [SEG_W-1:0]  seg;
    logic [MANT_W-1:0] mant;
    logic [MAG_W-1:0]  base;
    int                sh;
    seg  = c[CODE_W-1 -: SEG_W];
    mant = c[MANT_W-1:0];
    sh   = (seg == '0) ? 1 : int'(seg);
    base = (seg == '0) ? '0 : (MAG_W'(1) << (MANT_W + int'(seg)));
    return base + (MAG_W'(mant) << sh) + (MAG_W'(1) << (sh - 1));
  endfunction

  function automatic logic [MAG_W-1:0] lin_mag(input logic [CODE_W-1:0] c);
    return {c, {PAD_W{1'b0}}};
  endfunction

  assign mag = (mode == MODE_SEGMENT) ? seg_mag(code) : lin_mag(code);
endmodule

// File: rtl/pcm_out_stage.sv
module pcm_out_stage
  import pcm_cmp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  pcm_mode_e         in_mode,
  output logic              q_valid,
  output logic [BYTE_W-1:0] q_byte,
  output pcm_mode_e         q_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_byte  <= '0;
      q_mode  <= MODE_LINEAR;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_byte <= in_byte;
        q_mode <= in_mode;
      end
    end
  end
endmodule

// File: rtl/pcm_compander_top.sv
module pcm_compander_top
  import pcm_cmp_pkg::*;
#(
  parameter int MAG_W  = 12,
  parameter int SEG_W  = 3,
  parameter int MANT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sign,
  input  logic [MAG_W-1:0]         in_mag,
  input  logic                     mode_alaw,
  output logic                     out_valid,
  output logic [SEG_W+MANT_W:0]    out_byte,
  output logic                     out_sign,
  output logic [MAG_W-1:0]         out_mag
);
  localparam int CODE_W = SEG_W + MANT_W;
  localparam int BYTE_W = CODE_W + 1;

  pcm_mode_e         mode_in;
  pcm_mode_e         held_mode;
  logic [CODE_W-1:0] enc_code;
  logic [BYTE_W-1:0] enc_byte;
  logic [CODE_W-1:0] held_code;
  logic [SEG_W-1:0]  held_seg;

  assign mode_in  = mode_alaw ? MODE_SEGMENT : MODE_LINEAR;
  assign enc_byte = {in_sign, enc_code};

  pcm_seg_encoder #(.MAG_W(MAG_W), .SEG_W(SEG_W), .MANT_W(MANT_W)) enc_i (
    .mag  (in_mag),
    .mode (mode_in),
    .code (enc_code)
  );

  pcm_out_stage #(.BYTE_W(BYTE_W)) stage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (enc_byte),
    .in_mode  (mode_in),
    .q_valid  (out_valid),
    .q_byte   (out_byte),
    .q_mode   (held_mode)
  );

  assign held_code = out_byte[CODE_W-1:0];
  assign held_seg  = held_code[CODE_W-1 -: SEG_W];
  assign out_sign  = out_byte[BYTE_W-1];

  pcm_seg_decoder #(.MAG_W(MAG_W), .SEG_W(SEG_W), .MANT_W(MANT_W)) dec_i (
    .code (held_code),
    .mode (held_mode),
    .mag  (out_mag)
  );

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_byte[BYTE_W-1] == $past(in_sign)) && (out_sign == $past(in_sign)));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_byte) && $stable(out_mag));
  // R5
  lin_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && held_mode == MODE_LINEAR) |-> (out_mag[MAG_W-CODE_W-1:0] == '0));
  // R11
  seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && held_mode == MODE_SEGMENT) |->
      ((held_seg == '0) ? ((out_mag >> (MANT_W + 1)) == '0)
                        : ((out_mag >> (MANT_W + int'(held_seg))) == MAG_W'(1))));
endmodule

// File: tb/pcm_compander_top_tb.sv
module pcm_compander_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [11:0] in_mag = '0;
  logic        mode_alaw = 1'b0;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_sign;
  logic [11:0] out_mag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_compander_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_mag(in_mag), .mode_alaw(mode_alaw), .out_valid(out_valid),
    .out_byte(out_byte), .out_sign(out_sign), .out_mag(out_mag)
  );

  function automatic int lo_of(int c);
    int seg = c >> 4;
    int mant = c & 15;
    if (seg == 0) return mant * 2;
    return (1 << (seg + 4)) + mant * (1 << seg);
  endfunction

  function automatic int step_of(int c);
    return ((c >> 4) == 0) ? 2 : (1 << (c >> 4));
  endfunction

  function automatic int ref_code(int m);
    int c = 0;
    for (int k = 0; k < 128; k++) if (lo_of(k) <= m) c = k;
    return c;
  endfunction

  function automatic int ref_mag(int c);
    return lo_of(c) + step_of(c) / 2;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apply(bit s, int m, bit md);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sign   = s;
    in_mag    = 12'(m);
    mode_alaw = md;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 valid", int'(out_valid), 0);
    check("R1 byte", int'(out_byte), 0);
    check("R1 mag", int'(out_mag), 0);
    check("R1 sign", int'(out_sign), 0);
  endtask

  task automatic t_points;
    int mags[8]  = '{'h02E, 'h03E, 'h060, 'h07C, 'h7C0, 'h800, 'hC00, 'hF80};
    int codes[8] = '{'h17, 'h1F, 'h28, 'h2F, 'h6F, 'h70, 'h78, 'h7F};
    for (int i = 0; i < 8; i++) begin
      apply(1'b0, mags[i], 1'b1);
      check("R8 code point", int'(out_byte), codes[i]);
    end
  endtask

  task automatic t_lin_sweep;
    for (int m = 0; m < 4096; m++) begin
      apply(m[0], m, 1'b0);
      check("R5 lin code", int'(out_byte), (int'(m[0]) << 7) | (m >> 5));
      check("R5 lin expand", int'(out_mag), (m >> 5) << 5);
    end
  endtask

  task automatic t_seg_sweep;
    for (int m = 0; m < 4096; m++) begin
      int c = ref_code(m);
      apply(m[1], m, 1'b1);
      check("R6 R7 seg code", int'(out_byte), (int'(m[1]) << 7) | c);
      check("R9 seg expand", int'(out_mag), ref_mag(c));
      check("R11 round trip", ref_code(int'(out_mag)), c);
    end
  endtask

  task automatic t_sign;
    apply(1'b1, 'h123, 1'b0);
    check("R2 sign lin byte", int'(out_byte[7]), 1);
    check("R2 sign lin out", int'(out_sign), 1);
    apply(1'b1, 'h005, 1'b1);
    check("R2 sign seg byte", int'(out_byte), 'h82);
    check("R2 sign seg out", int'(out_sign), 1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_sign = 1'b0; in_mag = 12'h7C0; mode_alaw = 1'b1;
    #1;
    check("R3 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    check("R3 valid after one", int'(out_valid), 1);
    check("R3 byte after one", int'(out_byte), 'h6F);
  endtask

  task automatic t_hold;
    apply(1'b1, 'h060, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_sign = 1'b0; in_mag = 12'hFFF; mode_alaw = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 idle valid", int'(out_valid), 0);
    check("R4 held byte", int'(out_byte), 'hA8);
    check("R4 held mag", int'(out_mag), ref_mag('h28));
    check("R4 held sign", int'(out_sign), 1);
  endtask

  task automatic t_mode_flip;
    @(negedge clk);
    in_valid = 1'b1; in_sign = 1'b0; in_mag = 12'h03E; mode_alaw = 1'b1;
    @(negedge clk);
    check("R10 first seg byte", int'(out_byte), 'h1F);
    check("R10 first seg mag", int'(out_mag), ref_mag('h1F));
    in_mag = 12'h03E; mode_alaw = 1'b0;
    @(negedge clk);
    check("R10 second lin byte", int'(out_byte), 'h01);
    check("R10 second lin mag", int'(out_mag), 'h020);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_points();
    t_sign();
    t_latency();
    t_hold();
    t_mode_flip();
    t_lin_sweep();
    t_seg_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule